// File: doc/BRIEF.md
# Multiplexed-Bus Program ROM Slave

This block takes the place of a program ROM on an eight-line shared memory bus. The master does not present a parallel address. It drives a short strobed load sequence over the same eight data lines, then turns the bus around and reads bytes back. Each later strobe advances a slave program counter, so the next byte appears on the bus. The block holds four banks of program image in an internal synchronous memory. A small fill port writes the image. The two bank-select lines are captured while the address is being loaded.

The bus inputs (bus reset, direction control, strobe, bank select and data) are asynchronous to the block clock, so they pass through a two-flop synchroniser together. A strobe takes effect at its rising edge, when the line returns high. The load phase is the state in which the bus reset and the direction control are both low. In that phase the three strobes carry, in order:

- a byte that is discarded, while the bank-select lines are captured;
- the low half of the address;
- the high half of the address.

The counter wraps at the top of the program window and stays in the same bank. A read of an address outside the window returns 0xFF.

Top module: `mbus_rom_slave`

## Requirements
- R1: While `rst` is high and afterwards, whenever `bus_oe` is low, `bus_out` is 0x00. Directly after reset, `bus_oe` is low.
- R2: `bus_oe` follows `dir` after the synchroniser and output registers. The block drives the bus only while `dir` is high and releases it while `dir` is low.
- R3: In the load phase (`bus_rst_n` low, `dir` low), three strobes carry a first byte, then LO, then HI. When `dir` goes high, `bus_out` shows the image byte at address {HI,LO} of the captured bank. For example, the sequence 0x00, 0x00, 0x20 selects address 0x2000.
- R4: The bank is the value of `bank_sel` at the first load strobe. Later changes of `bank_sel` have no effect until the next load sequence.
- R5: Outside the load phase, each strobe raises the counter by one, and the byte at the new address appears on `bus_out`.
- R6: Stepping from address WIN_HI returns the counter to WIN_LO in the same bank.
- R7: Strobes in the load phase after the third one are ignored. They change neither the address nor the bank.
- R8: Every falling edge of `bus_rst_n` restarts the load sequence at its first byte, even if the previous sequence was left incomplete.
- R9: A counter address outside WIN_LO..WIN_HI reads as 0xFF. Stepping from WIN_LO-1 leads to WIN_LO.
- R10: A strobe acts only when the line returns high. Holding the strobe low leaves `bus_out` unchanged.
- R11: The fill port writes byte `fill_data` at address WIN_LO+`fill_off` of bank `fill_bank` on a clock with `fill_we` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst_n | input | 1 | Bus reset from the master, active low |
| dir | input | 1 | Direction control: high lets the slave drive |
| strb_n | input | 1 | Strobe, active low, acted on at its rise |
| bank_sel | input | 2 | Bank-select lines |
| bus_in | input | 8 | Bus value seen by the slave |
| fill_we | input | 1 | Image write enable |
| fill_bank | input | 2 | Image write bank |
| fill_off | input | OFF_W | Image write offset from WIN_LO |
| fill_data | input | 8 | Image write byte |
| bus_out | output | 8 | Byte driven onto the bus |
| bus_oe | output | 1 | Bus drive enable for the pad |

## Verification
The bench builds the block with a 64-byte window (WIN_LO 0x2000, WIN_HI 0x203F). This shrinks the image to 256 bytes, so every byte of every bank is read back through strobe steps. The wrap at WIN_HI and the crossing from WIN_LO-1 into the window both fall within a few strobes of a load. The small window also puts 0x2040 above the window, which makes the 0xFF fill reachable on both sides of it.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int BYTE_W = 8;
  localparam int BANK_W = 2;
  localparam int NBANK  = 1 << BANK_W;
  localparam int PC_W   = 2 * BYTE_W;

  typedef enum logic [1:0] {
    LD_BANK = 2'd0,
    LD_LO   = 2'd1,
    LD_HI   = 2'd2,
    LD_DONE = 2'd3
  } ld_state_e;

  typedef struct packed {
    logic              rst_n;
    logic              dir;
    logic              stb_n;
    logic [BANK_W-1:0] bank;
    logic [BYTE_W-1:0] data;
  } bus_smp_t;

  localparam bus_smp_t SMP_IDLE = '{rst_n: 1'b1, dir: 1'b0, stb_n: 1'b1,
                                    bank: '0, data: '0};
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int           W       = 8,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter logic [PC_W-1:0] WIN_LO = 16'h2000,
  parameter logic [PC_W-1:0] WIN_HI = 16'h20FF
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_smp_t          smp,
  output logic [PC_W-1:0]   pc,
  output logic [BANK_W-1:0] bank,
  output ld_state_e         ld_st,
  output logic              step,
  output logic              stb_rise,
  output logic              brst_fall
);
  logic              stb_prev, brst_prev, in_load;
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_prev  <= 1'b1;
      brst_prev <= 1'b1;
    end else begin
      stb_prev  <= smp.stb_n;
      brst_prev <= smp.rst_n;
    end
  end

  assign stb_rise  = smp.stb_n & ~stb_prev;
  assign brst_fall = ~smp.rst_n & brst_prev;
  assign in_load   = ~smp.rst_n & ~smp.dir;
  assign step      = stb_rise & ~in_load & ~brst_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_st <= LD_BANK;
      bank  <= '0;
      lo_q  <= '0;
      pc    <= WIN_LO;
    end else if (brst_fall) begin
      ld_st <= LD_BANK;
    end else if (stb_rise) begin
      if (in_load) begin
        unique case (ld_st)
          LD_BANK: begin bank <= smp.bank; ld_st <= LD_LO; end
          LD_LO:   begin lo_q <= smp.data; ld_st <= LD_HI; end
          LD_HI:   begin pc <= {smp.data, lo_q}; ld_st <= LD_DONE; end
          default: ;
        endcase
      end else begin
        pc <= (pc == WIN_HI) ? WIN_LO : pc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbus_rom.sv
module mbus_rom
  import mbus_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int OFF_W = $clog2(DEPTH),
  localparam int TOT   = NBANK * DEPTH,
  localparam int IDX_W = $clog2(TOT)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] mem [TOT];
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  assign wr_idx = IDX_W'(wr_bank) * IDX_W'(DEPTH) + IDX_W'(wr_off);
  assign rd_idx = IDX_W'(rd_bank) * IDX_W'(DEPTH) + IDX_W'(rd_off);

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_off) < DEPTH)) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/mbus_rom_slave.sv
module mbus_rom_slave
  import mbus_pkg::*;
#(
  parameter logic [15:0] WIN_LO = 16'h2000,
  parameter logic [15:0] WIN_HI = 16'h20FF,
  parameter int          SYNC_STAGES = 2,
  localparam int DEPTH = int'(WIN_HI) - int'(WIN_LO) + 1,
  localparam int OFF_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst_n,
  input  logic              dir,
  input  logic              strb_n,
  input  logic [1:0]        bank_sel,
  input  logic [7:0]        bus_in,
  input  logic              fill_we,
  input  logic [1:0]        fill_bank,
  input  logic [OFF_W-1:0]  fill_off,
  input  logic [7:0]        fill_data,
  output logic [7:0]        bus_out,
  output logic              bus_oe
);
  localparam int SMP_W = $bits(bus_smp_t);

  bus_smp_t          raw, smp;
  logic [SMP_W-1:0]  smp_vec;
  logic [PC_W-1:0]   pc_w;
  logic [BANK_W-1:0] bank_w;
  ld_state_e         ld_w;
  logic              step_w, stb_rise_w, brst_fall_w;
  logic [BYTE_W-1:0] rd_w;
  logic [OFF_W-1:0]  off_w;
  logic              in_win, in_win_q, oe_q;

  assign raw = '{rst_n: bus_rst_n, dir: dir, stb_n: strb_n,
                 bank: bank_sel, data: bus_in};

  mbus_sync #(.W(SMP_W), .STAGES(SYNC_STAGES), .RST_VAL(SMP_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (smp_vec)
  );
  assign smp = bus_smp_t'(smp_vec);

  mbus_seq #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .smp       (smp),
    .pc        (pc_w),
    .bank      (bank_w),
    .ld_st     (ld_w),
    .step      (step_w),
    .stb_rise  (stb_rise_w),
    .brst_fall (brst_fall_w)
  );

  assign in_win = (pc_w >= WIN_LO) && (pc_w <= WIN_HI);
  assign off_w  = OFF_W'(pc_w - WIN_LO);

  mbus_rom #(.DEPTH(DEPTH)) u_rom (
    .clk     (clk),
    .wr_en   (fill_we),
    .wr_bank (fill_bank),
    .wr_off  (fill_off),
    .wr_data (fill_data),
    .rd_bank (bank_w),
    .rd_off  (off_w),
    .rd_data (rd_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_win_q <= 1'b0;
      oe_q     <= 1'b0;
      bus_out  <= '0;
      bus_oe   <= 1'b0;
    end else begin
      in_win_q <= in_win;
      oe_q     <= smp.dir;
      bus_oe   <= oe_q;
      bus_out  <= oe_q ? (in_win_q ? rd_w : 8'hFF) : 8'h00;
    end
  end
endmodule

// File: rtl/mbus_rom_slave_chk.sv
module mbus_rom_slave_chk
  import mbus_pkg::*;
#(
  parameter logic [15:0] WIN_LO = 16'h2000,
  parameter logic [15:0] WIN_HI = 16'h20FF
) (
  input logic              clk,
  input logic              rst,
  input logic              dir,
  input logic              bus_oe,
  input logic [7:0]        bus_out,
  input logic [PC_W-1:0]   pc,
  input logic [BANK_W-1:0] bank,
  input ld_state_e         ld_st,
  input logic              step,
  input logic              stb_rise,
  input logic              brst_fall
);
  logic [3:0] age;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst)           age <= '0;
    else if (!age[3])  age <= age + 1'b1;
  end
  assign warm = age >= 4'd7;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> bus_out == 8'h00);  // R1

  AST_OE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (warm && !dir && !$past(dir) && !$past(dir, 2) && !$past(dir, 3)
     && !$past(dir, 4) && !$past(dir, 5)) |-> !bus_oe);  // R2

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (warm && bank != $past(bank)) |-> ($past(stb_rise) && $past(ld_st) == LD_BANK));  // R4

  AST_STEP_PLUS1: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(step) && $past(pc) != WIN_HI) |-> pc == $past(pc) + 16'd1);  // R5

  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(step) && $past(pc) == WIN_HI) |-> pc == WIN_LO);  // R6

  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(brst_fall)) |-> ld_st == LD_BANK);  // R8

  AST_PC_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    (warm && pc != $past(pc)) |-> $past(stb_rise));  // R10
endmodule

bind mbus_rom_slave mbus_rom_slave_chk #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dir       (dir),
  .bus_oe    (bus_oe),
  .bus_out   (bus_out),
  .pc        (pc_w),
  .bank      (bank_w),
  .ld_st     (ld_w),
  .step      (step_w),
  .stb_rise  (stb_rise_w),
  .brst_fall (brst_fall_w)
);

// File: tb/sim_mbus_rom_slave.sv
module sim_mbus_rom_slave;
  localparam logic [15:0] WIN_LO = 16'h2000;
  localparam logic [15:0] WIN_HI = 16'h203F;
  localparam int DEPTH = 64;
  localparam int OFF_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_rst_n = 1'b1, dir = 1'b0, strb_n = 1'b1;
  logic [1:0] bank_sel = '0;
  logic [7:0] bus_in = '0;
  logic fill_we = 1'b0;
  logic [1:0] fill_bank = '0;
  logic [OFF_W-1:0] fill_off = '0;
  logic [7:0] fill_data = '0;
  logic [7:0] bus_out;
  logic bus_oe;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mbus_rom_slave #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u0 (
    .clk(clk), .rst(rst), .bus_rst_n(bus_rst_n), .dir(dir), .strb_n(strb_n),
    .bank_sel(bank_sel), .bus_in(bus_in), .fill_we(fill_we), .fill_bank(fill_bank),
    .fill_off(fill_off), .fill_data(fill_data), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  function automatic logic [7:0] pat(int b, int o);
    return 8'(o * 7 + 1) ^ 8'(b * 73);
  endfunction

  function automatic logic [7:0] expv(int b, int a);
    if (a >= int'(WIN_LO) && a <= int'(WIN_HI)) return pat(b, a - int'(WIN_LO));
    return 8'hFF;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    strb_n = 1'b0; wait_clk(4);
    strb_n = 1'b1; wait_clk(8);
  endtask

  task automatic do_load(logic [1:0] b0, logic [1:0] b1, logic [7:0] first,
                         logic [7:0] lo, logic [7:0] hi, int extra);
    dir = 1'b1; bus_rst_n = 1'b1; bank_sel = b0; wait_clk(4);
    bus_rst_n = 1'b0; wait_clk(4);
    dir = 1'b0; wait_clk(4);
    bus_in = first; pulse();
    bank_sel = b1;
    bus_in = lo; pulse();
    bus_in = hi; pulse();
    for (int k = 0; k < extra; k++) begin
      bus_in = 8'hC3 + 8'(k); bank_sel = ~b0; pulse();
    end
    dir = 1'b1; wait_clk(6);
    bus_rst_n = 1'b1; wait_clk(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(6);
    chk("R1 reset oe", {7'd0, bus_oe}, 8'h00);
    chk("R1 reset out", bus_out, 8'h00);
    rst = 1'b0;
    wait_clk(4);
    chk("R1 idle out", bus_out, 8'h00);

    // R11: fill every byte of every bank
    for (int b = 0; b < 4; b++) begin
      for (int o = 0; o < DEPTH; o++) begin
        fill_we = 1'b1; fill_bank = 2'(b); fill_off = OFF_W'(o); fill_data = pat(b, o);
        wait_clk(1);
      end
    end
    fill_we = 1'b0;

    // R3, R5, R6, R11: full sweep of each bank through strobe steps, then wrap
    for (int b = 0; b < 4; b++) begin
      do_load(2'(b), 2'(b), 8'h00, 8'h00, 8'h20, 0);
      chk("R2 oe high", {7'd0, bus_oe}, 8'h01);
      chk("R3 load 0x2000", bus_out, expv(b, 16'h2000));
      for (int i = 1; i < DEPTH; i++) begin
        pulse();
        chk("R5 step", bus_out, expv(b, 16'h2000 + i));
      end
      pulse();
      chk("R6 wrap", bus_out, expv(b, 16'h2000));
    end

    // R3: load into the middle of the window
    do_load(2'd2, 2'd2, 8'h5A, 8'h25, 8'h20, 0);
    chk("R3 mid load", bus_out, expv(2, 16'h2025));

    // R4: bank_sel changes after the first strobe
    do_load(2'd1, 2'd3, 8'h00, 8'h07, 8'h20, 0);
    chk("R4 bank latched", bus_out, expv(1, 16'h2007));
    bank_sel = 2'd0; pulse();
    chk("R4 bank kept on step", bus_out, expv(1, 16'h2008));

    // R7: extra strobes in the load phase
    do_load(2'd3, 2'd3, 8'h00, 8'h10, 8'h20, 3);
    chk("R7 extra strobes ignored", bus_out, expv(3, 16'h2010));

    // R8: incomplete sequence, then a new one
    dir = 1'b1; bank_sel = 2'd3; wait_clk(4);
    bus_rst_n = 1'b0; wait_clk(4);
    dir = 1'b0; wait_clk(4);
    bus_in = 8'h00; pulse();
    bus_in = 8'h30; pulse();
    dir = 1'b1; wait_clk(4);
    bus_rst_n = 1'b1; wait_clk(8);
    do_load(2'd1, 2'd1, 8'h00, 8'h05, 8'h20, 0);
    chk("R8 restart", bus_out, expv(1, 16'h2005));

    // R9: outside the window
    do_load(2'd0, 2'd0, 8'h00, 8'h00, 8'h10, 0);
    chk("R9 below window", bus_out, 8'hFF);
    do_load(2'd2, 2'd2, 8'h00, 8'h40, 8'h20, 0);
    chk("R9 above window", bus_out, 8'hFF);
    pulse();
    chk("R9 above window step", bus_out, 8'hFF);
    do_load(2'd3, 2'd3, 8'h00, 8'hFF, 8'h1F, 0);
    chk("R9 0x1FFF", bus_out, 8'hFF);
    pulse();
    chk("R9 step into window", bus_out, expv(3, 16'h2000));

    // R10: strobe held low does nothing until released
    do_load(2'd0, 2'd0, 8'h00, 8'h00, 8'h20, 0);
    strb_n = 1'b0; wait_clk(12);
    chk("R10 held low", bus_out, expv(0, 16'h2000));
    strb_n = 1'b1; wait_clk(8);
    chk("R10 after rise", bus_out, expv(0, 16'h2001));

    // R2, R1: direction low releases the bus
    dir = 1'b0; wait_clk(8);
    chk("R2 oe low", {7'd0, bus_oe}, 8'h00);
    chk("R1 released out", bus_out, 8'h00);
    dir = 1'b1; wait_clk(8);
    chk("R2 oe back", {7'd0, bus_oe}, 8'h01);
    chk("R2 data back", bus_out, expv(0, 16'h2001));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule